// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control and status side of a successive-approximation converter inside a microcontroller, modelled cycle by cycle. Software writes one control/status register that holds an enable, a start request, an auto-trigger bit, a completion flag, an interrupt enable and a prescaler field. From these the block times each conversion against the system clock. At the end of a conversion it raises the flag, a one-cycle completion pulse and, if enabled, an interrupt request.

When a conversion starts, the block emits a one-cycle trigger. The trigger carries the input-mux descriptor that the current mux select picks from a small table the host loads. An external stimulus model can then supply the sample value for that input. The block also keeps a small result-read state for the result-formatting logic beside it. Completion returns that state to "fresh".

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, csr_rdata reads 0, irq, trig_pulse and done_pulse are low, rd_state is 0, and no conversion is pending.
- R2: The register fields are: bit 7 enable, bit 6 start, bit 5 auto-trigger, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 prescaler. Auto-trigger, interrupt enable and prescaler read back exactly as written.
- R3: Software cannot clear the start bit. Writing 0 to it while it is set changes nothing, and it stays set until completion. A write that sets start while enable is 0 (before and in the write) is ignored and produces no trigger.
- R4: A write that moves start from 0 to 1 gives trig_pulse high for exactly the cycle after the write edge. During that cycle trig_desc equals the table entry that mux_sel selected at the write edge.
- R5: The divider is D = 2^p for prescaler p, with p = 0 treated as 1. A normal conversion has its done_pulse visible 13*D cycles after the write edge that started it. The prescaler is taken from the starting write.
- R6: The first conversion after enable goes from 0 to 1 lasts 25*D cycles. This includes a write that enables and starts at once. Later conversions last 13*D cycles.
- R7: On completion the flag is set and the start bit is cleared in the same edge, and done_pulse is high for one cycle.
- R8: Writing 1 to bit 4 clears the flag, and writing 0 leaves it unchanged. irq is high exactly when the flag and the interrupt enable are both set.
- R9: Writing enable to 0 while a conversion runs clears start at once. That conversion never completes, so there is no done_pulse and no flag.
- R10: rd_state is 0 (fresh), 1 (low half read) or 2 (both read). rd_lo in state 0 gives 1. rd_hi in any state gives 2. rd_lo in state 2 has no effect. Completion returns the state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| mux_sel | input | 3 | Current input-mux select |
| desc_wr | input | 1 | Descriptor table write strobe |
| desc_idx | input | 3 | Descriptor table write index |
| desc_wdata | input | 16 | Descriptor table write data |
| rd_lo | input | 1 | Low half of result read |
| rd_hi | input | 1 | High half of result read |
| csr_rdata | output | 8 | Register contents |
| trig_pulse | output | 1 | Conversion start trigger |
| trig_desc | output | 16 | Descriptor sent with the trigger |
| done_pulse | output | 1 | Conversion completed |
| irq | output | 1 | Interrupt request |
| rd_state | output | 2 | Result-read state |

## Verification
The hardest case to reach is a race between software and a running conversion. One example is a write that tries to clear start while the count is still going. Another is a disable that lands partway through a long first conversion. The stimulus starts conversions with slow prescalers and places writes a fixed number of cycles after the start edge, well inside the count. The scoreboard holds one expected completion cycle for each start. It removes the entry of an aborted conversion, so any done_pulse that still appears is reported as unexpected.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int PRESC_W   = 3,
  parameter int MUX_W     = 3,
  parameter int DESC_W    = 16,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_wr,
  input  logic [PRESC_W+4:0]    csr_wdata,
  input  logic [MUX_W-1:0]      mux_sel,
  input  logic                  desc_wr,
  input  logic [MUX_W-1:0]      desc_idx,
  input  logic [DESC_W-1:0]     desc_wdata,
  input  logic                  rd_lo,
  input  logic                  rd_hi,
  output logic [PRESC_W+4:0]    csr_rdata,
  output logic                  trig_pulse,
  output logic [DESC_W-1:0]     trig_desc,
  output logic                  done_pulse,
  output logic                  irq,
  output logic [1:0]            rd_state
);
  localparam int NUM_MUX = 1 << MUX_W;
  localparam int DIV_W   = (1 << PRESC_W) - 1;
  localparam int LEN_W   = $clog2(FIRST_LEN + 1);
  localparam int B_IE    = PRESC_W;
  localparam int B_IF    = PRESC_W + 1;
  localparam int B_AT    = PRESC_W + 2;
  localparam int B_ST    = PRESC_W + 3;
  localparam int B_EN    = PRESC_W + 4;
  localparam logic [LEN_W-1:0] FIRST_LIM = LEN_W'(FIRST_LEN - 1);
  localparam logic [LEN_W-1:0] NORM_LIM  = LEN_W'(NORM_LEN - 1);

  logic               en_q, st_q, at_q, if_q, ie_q, first_q;
  logic [PRESC_W-1:0] ps_q;
  logic [DIV_W-1:0]   div_lim_q, pre_cnt_q, div_lim_new;
  logic [LEN_W-1:0]   len_lim_q, adc_cnt_q;
  logic               trig_q, done_q;
  logic [DESC_W-1:0]  trig_desc_q;
  logic [1:0]         rd_q;
  logic [DESC_W-1:0]  desc_mem [NUM_MUX];
  logic [PRESC_W-1:0] ps_eff;

  wire en_rise  = csr_wr &  csr_wdata[B_EN] & ~en_q;
  wire en_fall  = csr_wr & ~csr_wdata[B_EN] &  en_q;
  wire start_go = csr_wr & csr_wdata[B_EN] & csr_wdata[B_ST] & ~st_q;
  wire tick     = st_q & (pre_cnt_q == div_lim_q);
  wire finish   = tick & (adc_cnt_q == len_lim_q) & ~en_fall;

  assign ps_eff = (csr_wdata[PRESC_W-1:0] == '0) ? PRESC_W'(1) : csr_wdata[PRESC_W-1:0];

  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      div_lim_new[i] = (i < int'(ps_eff));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; at_q <= 1'b0; ie_q <= 1'b0; ps_q <= '0;
    end else if (csr_wr) begin
      en_q <= csr_wdata[B_EN];
      at_q <= csr_wdata[B_AT];
      ie_q <= csr_wdata[B_IE];
      ps_q <= csr_wdata[PRESC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          if_q <= 1'b0;
    else if (finish)                     if_q <= 1'b1;
    else if (csr_wr && csr_wdata[B_IF])  if_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        first_q <= 1'b0;
    else if (en_rise)  first_q <= 1'b1;
    else if (finish)   first_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  st_q <= 1'b0;
    else if (en_fall || finish)  st_q <= 1'b0;
    else if (start_go)           st_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt_q <= '0; adc_cnt_q <= '0; div_lim_q <= '0; len_lim_q <= '0;
    end else if (start_go) begin
      pre_cnt_q <= '0;
      adc_cnt_q <= '0;
      div_lim_q <= div_lim_new;
      len_lim_q <= (en_rise || first_q) ? FIRST_LIM : NORM_LIM;
    end else if (st_q) begin
      if (tick) begin
        pre_cnt_q <= '0;
        adc_cnt_q <= adc_cnt_q + 1'b1;
      end else begin
        pre_cnt_q <= pre_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MUX; i++) desc_mem[i] <= '0;
    end else if (desc_wr) begin
      desc_mem[desc_idx] <= desc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0; trig_desc_q <= '0; done_q <= 1'b0;
    end else begin
      trig_q <= start_go;
      done_q <= finish;
      if (start_go) trig_desc_q <= desc_mem[mux_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       rd_q <= 2'd0;
    else if (finish)                  rd_q <= 2'd0;
    else if (rd_hi)                   rd_q <= 2'd2;
    else if (rd_lo && rd_q == 2'd0)   rd_q <= 2'd1;
  end

  assign csr_rdata  = {en_q, st_q, at_q, if_q, ie_q, ps_q};
  assign irq        = if_q & ie_q;
  assign trig_pulse = trig_q;
  assign trig_desc  = trig_desc_q;
  assign done_pulse = done_q;
  assign rd_state   = rd_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int PRESC_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PRESC_W+4:0] csr_rdata,
  input logic               trig_pulse,
  input logic               done_pulse,
  input logic               irq,
  input logic [1:0]         rd_state
);
  localparam int B_IF = PRESC_W + 1;
  localparam int B_ST = PRESC_W + 3;
  localparam int B_EN = PRESC_W + 4;

  a_r4_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  a_r4_trig_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> csr_rdata[B_ST]);
  a_r7_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[B_IF]) |-> done_pulse);
  a_r7_done_effects: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (csr_rdata[B_IF] && !csr_rdata[B_ST]));
  a_r3_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csr_rdata[B_ST]) |-> (done_pulse || !csr_rdata[B_EN]));
  a_r9_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[B_EN] |-> !csr_rdata[B_ST]);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr_rdata[B_IF]);
  a_r10_rd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state != 2'd3);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_rdata(csr_rdata), .trig_pulse(trig_pulse),
  .done_pulse(done_pulse), .irq(irq), .rd_state(rd_state)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [2:0]  mux_sel = '0;
  logic        desc_wr = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [15:0] desc_wdata = '0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0]  csr_rdata;
  logic        trig_pulse, done_pulse, irq;
  logic [15:0] trig_desc;
  logic [1:0]  rd_state;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .mux_sel(mux_sel), .desc_wr(desc_wr), .desc_idx(desc_idx),
    .desc_wdata(desc_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .csr_rdata(csr_rdata), .trig_pulse(trig_pulse), .trig_desc(trig_desc),
    .done_pulse(done_pulse), .irq(irq), .rd_state(rd_state)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int          exp_done_q[$];
  int          exp_trig_q[$];
  logic [15:0] exp_desc_q[$];

  function automatic logic [15:0] descv(input int i);
    return 16'hC300 ^ 16'(i * 16'h0111);
  endfunction

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pulse) begin
        if (exp_done_q.size() == 0) chk(0, "R9", "unexpected done_pulse", cyc, 0);
        else begin
          int e;
          e = exp_done_q.pop_front();
          chk(cyc == e, "R5,R6", "completion cycle", cyc, e);
        end
      end
      if (trig_pulse) begin
        if (exp_trig_q.size() == 0) chk(0, "R3", "unexpected trig_pulse", cyc, 0);
        else begin
          int t;
          logic [15:0] d;
          t = exp_trig_q.pop_front();
          d = exp_desc_q.pop_front();
          chk(cyc == t, "R4", "trigger cycle", cyc, t);
          chk(trig_desc == d, "R4", "trigger descriptor", trig_desc, d);
        end
      end
    end
  end

  task automatic wr_csr(input logic [7:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic go(input int p, input bit first, input int m, input bit ie);
    int d, len, w;
    d = (p == 0) ? 2 : (1 << p);
    len = first ? 25 : 13;
    @(negedge clk);
    mux_sel = 3'(m);
    w = cyc + 1;
    exp_done_q.push_back(w + len * d);
    exp_trig_q.push_back(w);
    exp_desc_q.push_back(descv(m));
    csr_wr = 1'b1; csr_wdata = {1'b1, 1'b1, 1'b0, 1'b0, ie, 3'(p)};
    @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic wait_done();
    while (exp_done_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_pulse(input bit lo, input bit hi);
    @(negedge clk); rd_lo = lo; rd_hi = hi;
    @(negedge clk); rd_lo = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(csr_rdata == 8'h00, "R1", "csr after reset", csr_rdata, 0);
    chk(!irq && !trig_pulse && !done_pulse, "R1", "outputs after reset",
        {irq, trig_pulse, done_pulse}, 0);
    chk(rd_state == 2'd0, "R1", "rd_state after reset", rd_state, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); desc_wr = 1'b1; desc_idx = 3'(i); desc_wdata = descv(i);
    end
    @(negedge clk); desc_wr = 1'b0;

    // R2: enable, auto-trigger, interrupt enable, prescaler 2
    wr_csr(8'hAA);
    chk(csr_rdata == 8'hAA, "R2", "field readback", csr_rdata, 8'hAA);

    // R6: first conversion after enable, D=4 -> 100 cycles
    go(2, 1, 3, 1);
    wait_done();
    chk(csr_rdata == 8'h9A, "R7", "flag set, start clear", csr_rdata, 8'h9A);
    chk(irq == 1'b1, "R8", "irq with flag and enable", irq, 1);

    // R8: writing 0 to flag keeps it, writing 1 clears it
    wr_csr(8'h8A);
    chk(csr_rdata == 8'h9A, "R8", "flag kept on write 0", csr_rdata, 8'h9A);
    wr_csr(8'h9A);
    chk(csr_rdata == 8'h8A, "R8", "flag cleared on write 1", csr_rdata, 8'h8A);
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);

    // R3: try to clear start mid-conversion; R10 read state walk
    go(0, 0, 5, 0);
    repeat (4) @(negedge clk);
    wr_csr(8'h80);
    chk(csr_rdata[6] == 1'b1, "R3", "start not clearable", csr_rdata[6], 1);
    rd_pulse(1, 0);
    chk(rd_state == 2'd1, "R10", "low read", rd_state, 1);
    rd_pulse(0, 1);
    chk(rd_state == 2'd2, "R10", "high read", rd_state, 2);
    rd_pulse(1, 0);
    chk(rd_state == 2'd2, "R10", "low read after both", rd_state, 2);
    wait_done();
    chk(rd_state == 2'd0, "R10", "completion resets read state", rd_state, 0);
    chk(csr_rdata == 8'h90, "R7", "flag set", csr_rdata, 8'h90);
    chk(irq == 1'b0, "R8", "irq masked by enable", irq, 0);
    wr_csr(8'h90);

    // R5: slowest divider, 13*128
    go(7, 0, 0, 0);
    wait_done();
    chk(csr_rdata == 8'h97, "R5", "flag after slow conversion", csr_rdata, 8'h97);
    wr_csr(8'h97);
    // R5: prescaler 1, same as 0
    go(1, 0, 7, 0);
    wait_done();
    wr_csr(8'h91);
    chk(csr_rdata == 8'h81, "R8", "flag cleared", csr_rdata, 8'h81);

    // R9: abort
    go(3, 0, 2, 0);
    repeat (20) @(negedge clk);
    wr_csr(8'h03);
    chk(csr_rdata == 8'h03, "R9", "disable clears start", csr_rdata, 8'h03);
    void'(exp_done_q.pop_back());
    repeat (150) @(negedge clk);
    chk(csr_rdata[4] == 1'b0, "R9", "no flag after abort", csr_rdata[4], 0);

    // R3: start while disabled ignored
    wr_csr(8'h41);
    chk(csr_rdata == 8'h01, "R3", "start ignored when disabled", csr_rdata, 8'h01);
    repeat (60) @(negedge clk);

    // R6: enable and start in one write -> 25*2
    go(1, 1, 6, 1);
    wait_done();
    chk(csr_rdata == 8'h99, "R6", "first conversion done", csr_rdata, 8'h99);
    chk(irq == 1'b1, "R8", "irq raised", irq, 1);
    // R6: next one normal length
    go(1, 0, 4, 1);
    wait_done();
    rd_pulse(0, 1);
    chk(rd_state == 2'd2, "R10", "high read from fresh", rd_state, 2);

    chk(exp_done_q.size() == 0 && exp_trig_q.size() == 0, "R4",
        "scoreboard drained", exp_done_q.size() + exp_trig_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end
endmodule